// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block is the digital half of a system supervisor. It drives a system reset and a watchdog fault strobe from a slow timing tick, a supply-good flag produced by an external comparator, and an active-low manual reset button. Reset is asserted whenever the supply is low or the button is held. Once every cause has cleared, reset stays asserted for a timeout chosen by a two-bit code, which gives the supply and the oscillator time to settle.

The watchdog measures time since the last sign of software activity. That sign is a two-wire bus start condition followed directly by a stop condition. The watchdog period comes from a second two-bit code, and one of its values turns the watchdog off. When the watchdog expires it raises a fault strobe for one tick interval and starts counting again. It does not assert reset. All durations are parameters counted in ticks, so a simulation can use short values.

Top module: `sup_wdt_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `sys_rst` is 1 and `wdt_fault` is 0.
- R2: `sys_rst` goes to 1 two clocks after `supply_ok` goes low and stays at 1 while the supply is low. Once every reset cause has cleared, the block counts ticks and releases `sys_rst` on the tick that completes the selected timeout.
- R3: Timeout code `tmo_sel` 0, 1, 2, 3 selects `TMO0`, `TMO1`, `TMO2`, `TMO3` ticks (defaults 50, 200, 400, 800 at a 1 kHz tick).
- R4: The manual reset input is synchronised and debounced. A new level is accepted only after it has differed from the accepted level on `DEB_TICKS` (16) consecutive ticks. A shorter low pulse has no effect on `sys_rst`.
- R5: An accepted low on `mr_n` asserts `sys_rst`. After an accepted release, the selected timeout runs before `sys_rst` is released.
- R6: When the watchdog reaches its period, `wdt_fault` goes high on that tick and stays high until the next tick. The count then restarts, and `sys_rst` is unaffected.
- R7: Watchdog code `wdp_sel` 0, 1, 2 selects `WDP0`, `WDP1`, `WDP2` ticks (defaults 25, 200, 1400). Code 3 disables the watchdog, which keeps it cleared and `wdt_fault` at 0.
- R8: A `bus_start` strobe followed by a `bus_stop` strobe, with no `bus_byte` strobe between them, clears the watchdog count. The clear takes effect one clock after the stop.
- R9: A start that is cut off by a `bus_byte` strobe, or that is never followed by a stop, does not restart the watchdog. A stop that has no start before it does not restart it either.
- R10: While `sys_rst` is 1, the watchdog count is held at zero and `wdt_fault` is 0.
- R11: `wdt_fault` rises and `sys_rst` falls only in the clock cycle after a `tick` strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high block reset (power-up) |
| tick | input | 1 | One-clock timing strobe, nominally 1 kHz |
| supply_ok | input | 1 | Supply-good flag from the external comparator, asynchronous |
| mr_n | input | 1 | Raw active-low manual reset input, asynchronous |
| tmo_sel | input | 2 | Reset timeout code |
| wdp_sel | input | 2 | Watchdog period code, 3 = off |
| bus_start | input | 1 | One-clock strobe: bus start condition seen |
| bus_stop | input | 1 | One-clock strobe: bus stop condition seen |
| bus_byte | input | 1 | One-clock strobe: a data byte was transferred |
| sys_rst | output | 1 | Registered system reset, active high |
| wdt_fault | output | 1 | Registered watchdog fault strobe, one tick long |

## Verification
The assertions check the following on every cycle: a synchronised supply-low or accepted manual low forces reset, no fault appears while reset is held or while the watchdog is off, a start-stop kick clears the count, and both output edges are aligned to ticks. The bench scenarios are needed for the exact release point of each timeout code, the debounce length and glitch rejection, the exact period of each watchdog code, and the broken start patterns that must not restart the watchdog. Each of these is compared against a behavioural model on every clock.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    WDP_SHORT = 2'd0,
    WDP_MID   = 2'd1,
    WDP_LONG  = 2'd2,
    WDP_OFF   = 2'd3
  } wdp_code_e;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1[i] <= RST_VAL[i];
        q_sync[i] <= RST_VAL[i];
      end else begin
        stage1[i] <= d_async[i];
        q_sync[i] <= stage1[i];
      end
    end
  end
endmodule

// File: rtl/sup_debounce.sv
module sup_debounce #(
  parameter int DEB_TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic lvl,
  output logic acc
);
  localparam int CW = (DEB_TICKS > 1) ? $clog2(DEB_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= 1'b1;
      run <= '0;
    end else if (tick) begin
      if (lvl != acc) begin
        if (run == LAST) begin
          acc <= lvl;
          run <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end else begin
        run <= '0;
      end
    end
  end
endmodule

// File: rtl/sup_reset_seq.sv
module sup_reset_seq #(
  parameter int TMO0 = 50,
  parameter int TMO1 = 200,
  parameter int TMO2 = 400,
  parameter int TMO3 = 800
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       cause,
  input  logic [1:0] sel,
  output logic       hold
);
  localparam int TMAX = int'(sup_pkg::max4(TMO0, TMO1, TMO2, TMO3));
  localparam int RW   = $clog2(TMAX + 1);

  logic [RW-1:0] cnt;
  logic [RW-1:0] lim;

  always_comb begin
    case (sel)
      2'd0:    lim = RW'(TMO0 - 1);
      2'd1:    lim = RW'(TMO1 - 1);
      2'd2:    lim = RW'(TMO2 - 1);
      default: lim = RW'(TMO3 - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || cause) begin
      hold <= 1'b1;
      cnt  <= '0;
    end else if (hold && tick) begin
      if (cnt >= lim) begin
        hold <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sup_bus_kick.sv
module sup_bus_kick (
  input  logic clk,
  input  logic rst,
  input  logic start_ev,
  input  logic stop_ev,
  input  logic byte_ev,
  output logic kick
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      kick  <= 1'b0;
    end else begin
      kick <= stop_ev & armed;
      if (start_ev)
        armed <= 1'b1;
      else if (byte_ev || stop_ev)
        armed <= 1'b0;
    end
  end
endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
  parameter int WDP0 = 25,
  parameter int WDP1 = 200,
  parameter int WDP2 = 1400
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       hold,
  input  logic       kick,
  input  logic [1:0] sel,
  output logic       fault,
  output logic       idle
);
  import sup_pkg::*;

  localparam int PMAX = int'(max4(WDP0, WDP1, WDP2, 1));
  localparam int PW   = $clog2(PMAX + 1);

  logic [PW-1:0] cnt;
  logic [PW-1:0] lim;
  logic          clr;
  wdp_code_e     code;

  assign code = wdp_code_e'(sel);
  assign clr  = hold | kick | (code == WDP_OFF);
  assign idle = (cnt == '0);

  always_comb begin
    case (code)
      WDP_SHORT: lim = PW'(WDP0 - 1);
      WDP_MID:   lim = PW'(WDP1 - 1);
      default:   lim = PW'(WDP2 - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt   <= '0;
      fault <= 1'b0;
    end else if (tick) begin
      if (cnt >= lim) begin
        cnt   <= '0;
        fault <= 1'b1;
      end else begin
        cnt   <= cnt + 1'b1;
        fault <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sup_wdt_ctrl.sv
module sup_wdt_ctrl #(
  parameter int TMO0      = 50,
  parameter int TMO1      = 200,
  parameter int TMO2      = 400,
  parameter int TMO3      = 800,
  parameter int WDP0      = 25,
  parameter int WDP1      = 200,
  parameter int WDP2      = 1400,
  parameter int DEB_TICKS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       supply_ok,
  input  logic       mr_n,
  input  logic [1:0] tmo_sel,
  input  logic [1:0] wdp_sel,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       bus_byte,
  output logic       sys_rst,
  output logic       wdt_fault
);
  logic [1:0] raw_in;
  logic [1:0] synced;
  logic       sup_good_s;
  logic       mr_s;
  logic       mr_acc;
  logic       cause;
  logic       kick;
  logic       wd_zero;

  assign raw_in     = {mr_n, supply_ok};
  assign sup_good_s = synced[0];
  assign mr_s       = synced[1];
  assign cause      = ~sup_good_s | ~mr_acc;

  sup_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst(rst), .d_async(raw_in), .q_sync(synced)
  );

  sup_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk(clk), .rst(rst), .tick(tick), .lvl(mr_s), .acc(mr_acc)
  );

  sup_reset_seq #(.TMO0(TMO0), .TMO1(TMO1), .TMO2(TMO2), .TMO3(TMO3)) u_rseq (
    .clk(clk), .rst(rst), .tick(tick), .cause(cause), .sel(tmo_sel), .hold(sys_rst)
  );

  sup_bus_kick u_kick (
    .clk(clk), .rst(rst), .start_ev(bus_start), .stop_ev(bus_stop),
    .byte_ev(bus_byte), .kick(kick)
  );

  sup_watchdog #(.WDP0(WDP0), .WDP1(WDP1), .WDP2(WDP2)) u_wd (
    .clk(clk), .rst(rst), .tick(tick), .hold(sys_rst), .kick(kick),
    .sel(wdp_sel), .fault(wdt_fault), .idle(wd_zero)
  );
endmodule

// File: rtl/sup_wdt_ctrl_chk.sv
module sup_wdt_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       sup_good_s,
  input logic       mr_acc,
  input logic       kick,
  input logic [1:0] wdp_sel,
  input logic       wd_zero,
  input logic       sys_rst,
  input logic       wdt_fault
);
  assert_supply_low_resets_R2: assert property (@(posedge clk) disable iff (rst)
    !sup_good_s |=> sys_rst);

  assert_manual_low_resets_R5: assert property (@(posedge clk) disable iff (rst)
    !mr_acc |=> sys_rst);

  assert_off_code_silent_R7: assert property (@(posedge clk) disable iff (rst)
    (wdp_sel == 2'b11) |=> !wdt_fault);

  assert_kick_clears_count_R8: assert property (@(posedge clk) disable iff (rst)
    kick |=> wd_zero);

  assert_no_fault_in_reset_R10: assert property (@(posedge clk) disable iff (rst)
    sys_rst |=> (!wdt_fault && wd_zero));

  assert_fault_rise_on_tick_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_fault) |-> $past(tick));

  assert_release_on_tick_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst) |-> $past(tick));
endmodule

bind sup_wdt_ctrl sup_wdt_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .sup_good_s(sup_good_s), .mr_acc(mr_acc),
  .kick(kick), .wdp_sel(wdp_sel), .wd_zero(wd_zero), .sys_rst(sys_rst),
  .wdt_fault(wdt_fault)
);

// File: tb/tb_sup_wdt_ctrl.sv
`timescale 1ns/1ps
module tb_sup_wdt_ctrl;
  localparam int T0 = 6, T1 = 10, T2 = 14, T3 = 20;
  localparam int P0 = 8, P1 = 12, P2 = 16;
  localparam int DEB = 16;
  localparam int TDIV = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic supply_ok = 1'b0;
  logic mr_n = 1'b1;
  logic [1:0] tmo_sel = 2'd0;
  logic [1:0] wdp_sel = 2'd3;
  logic bus_start = 1'b0, bus_stop = 1'b0, bus_byte = 1'b0;
  logic sys_rst, wdt_fault;

  int checks = 0;
  int errors = 0;
  int faults_seen = 0;
  int cycles = 0;
  bit done = 1'b0;
  string phase = "R1";

  always #2 clk = ~clk;

  sup_wdt_ctrl #(.TMO0(T0), .TMO1(T1), .TMO2(T2), .TMO3(T3),
                 .WDP0(P0), .WDP1(P1), .WDP2(P2), .DEB_TICKS(DEB)) dut (
    .clk(clk), .rst(rst), .tick(tick), .supply_ok(supply_ok), .mr_n(mr_n),
    .tmo_sel(tmo_sel), .wdp_sel(wdp_sel), .bus_start(bus_start),
    .bus_stop(bus_stop), .bus_byte(bus_byte), .sys_rst(sys_rst),
    .wdt_fault(wdt_fault)
  );

  int div = 0;
  always @(negedge clk) begin
    div  <= (div == TDIV - 1) ? 0 : div + 1;
    tick <= (div == TDIV - 1);
  end

  function automatic int tlim(input logic [1:0] s);
    case (s) 2'd0: return T0; 2'd1: return T1; 2'd2: return T2; default: return T3; endcase
  endfunction
  function automatic int plim(input logic [1:0] s);
    case (s) 2'd0: return P0; 2'd1: return P1; default: return P2; endcase
  endfunction

  // behavioural reference model
  bit m_s1s, m_s2s, m_s1m, m_s2m, m_acc, m_rst, m_armed, m_kick, m_fault;
  int m_dc, m_rc, m_wc;
  bit prev_tick, prev_fault;

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit n_acc, n_rst, n_armed, n_kick, n_fault;
    int n_dc, n_rc, n_wc;
    bit cause;
    n_acc = m_acc; n_dc = m_dc; n_rst = m_rst; n_rc = m_rc;
    n_armed = m_armed; n_kick = m_kick; n_wc = m_wc; n_fault = m_fault;
    if (rst) begin
      m_s1s = 0; m_s2s = 0; m_s1m = 1; m_s2m = 1;
      n_acc = 1; n_dc = 0; n_rst = 1; n_rc = 0;
      n_armed = 0; n_kick = 0; n_wc = 0; n_fault = 0;
    end else begin
      if (tick) begin
        if (m_s2m != m_acc) begin
          if (m_dc == DEB - 1) begin n_acc = m_s2m; n_dc = 0; end
          else n_dc = m_dc + 1;
        end else n_dc = 0;
      end
      cause = !m_s2s || !m_acc;
      if (cause) begin n_rst = 1; n_rc = 0; end
      else if (m_rst && tick) begin
        if (m_rc >= tlim(tmo_sel) - 1) begin n_rst = 0; n_rc = 0; end
        else n_rc = m_rc + 1;
      end
      n_kick = bus_stop && m_armed;
      if (bus_start) n_armed = 1;
      else if (bus_byte || bus_stop) n_armed = 0;
      if (m_rst || m_kick || wdp_sel == 2'd3) begin n_wc = 0; n_fault = 0; end
      else if (tick) begin
        if (m_wc >= plim(wdp_sel) - 1) begin n_wc = 0; n_fault = 1; end
        else begin n_wc = m_wc + 1; n_fault = 0; end
      end
      m_s2s = m_s1s; m_s1s = supply_ok;
      m_s2m = m_s1m; m_s1m = mr_n;
    end
    m_acc = n_acc; m_dc = n_dc; m_rst = n_rst; m_rc = n_rc;
    m_armed = n_armed; m_kick = n_kick; m_wc = n_wc; m_fault = n_fault;
    prev_tick = tick;
    #1;
    if (!done) begin
      check(phase, sys_rst, m_rst, "sys_rst vs model");
      check(phase, wdt_fault, m_fault, "wdt_fault vs model");
      if (wdt_fault && !prev_fault) begin
        faults_seen++;
        check("R11", prev_tick, 1'b1, "fault rise after tick");
      end
      prev_fault = wdt_fault;
    end
  end

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ev(input int which);
    @(negedge clk);
    bus_start = (which == 0); bus_stop = (which == 1); bus_byte = (which == 2);
    @(negedge clk);
    bus_start = 0; bus_stop = 0; bus_byte = 0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
      end
    end
  end

  initial begin
    int f0;
    clks(4);
    check("R1", sys_rst, 1'b1, "reset held during rst");
    check("R1", wdt_fault, 1'b0, "fault low during rst");
    rst = 0;
    clks(1);
    check("R1", sys_rst, 1'b1, "reset held after rst");

    // R2, R3: power-up release for every timeout code
    for (int s = 0; s < 4; s++) begin
      phase = "R3";
      tmo_sel = 2'(s);
      supply_ok = 0;
      clks(4);
      check("R2", sys_rst, 1'b1, "reset while supply low");
      supply_ok = 1;
      clks((tlim(2'(s)) - 1) * TDIV - 3);
      check("R3", sys_rst, 1'b1, "still held before timeout");
      clks(4 * TDIV + 3);
      check("R3", sys_rst, 1'b0, "released after timeout");
    end

    // R4: short glitch ignored
    phase = "R4";
    tmo_sel = 2'd0;
    mr_n = 0; clks(10 * TDIV); mr_n = 1;
    clks(20 * TDIV);
    check("R4", sys_rst, 1'b0, "short manual glitch ignored");

    // R5: long press asserts reset, release after debounce + timeout
    phase = "R5";
    mr_n = 0; clks((DEB + 3) * TDIV);
    check("R5", sys_rst, 1'b1, "manual press accepted");
    mr_n = 1; clks((DEB - 1) * TDIV);
    check("R4", sys_rst, 1'b1, "release not yet debounced");
    clks((T0 + 4) * TDIV);
    check("R5", sys_rst, 1'b0, "released after debounce and timeout");

    // R6, R7: free-running watchdog periods
    for (int s = 0; s < 3; s++) begin
      phase = "R6";
      wdp_sel = 2'(s);
      f0 = faults_seen;
      clks((3 * plim(2'(s)) + 2) * TDIV);
      checks++;
      if (faults_seen - f0 < 3) begin
        errors++;
        $display("FAIL R7 fault count actual=%0d expected>=3", faults_seen - f0);
      end
      check("R6", sys_rst, 1'b0, "expiry does not reset");
    end
    phase = "R7";
    wdp_sel = 2'd3;
    f0 = faults_seen;
    clks(60 * TDIV);
    checks++;
    if (faults_seen != f0) begin
      errors++;
      $display("FAIL R7 off code faults actual=%0d expected=0", faults_seen - f0);
    end

    // R8: regular start+stop kicks keep watchdog quiet
    phase = "R8";
    wdp_sel = 2'd1;
    f0 = faults_seen;
    for (int k = 0; k < 10; k++) begin
      pulse_ev(0); clks(3); pulse_ev(1);
      clks(6 * TDIV);
    end
    checks++;
    if (faults_seen != f0) begin
      errors++;
      $display("FAIL R8 kicked faults actual=%0d expected=0", faults_seen - f0);
    end

    // R9: broken patterns do not restart
    phase = "R9";
    f0 = faults_seen;
    for (int k = 0; k < 10; k++) begin
      if (k % 3 == 0) begin pulse_ev(0); pulse_ev(2); pulse_ev(1); end
      else if (k % 3 == 1) pulse_ev(0);
      else begin pulse_ev(2); pulse_ev(1); end
      clks(6 * TDIV);
    end
    checks++;
    if (faults_seen - f0 < 3) begin
      errors++;
      $display("FAIL R9 faults actual=%0d expected>=3", faults_seen - f0);
    end

    // R10: watchdog silent while reset held
    phase = "R10";
    wdp_sel = 2'd0;
    supply_ok = 0;
    clks(3);
    f0 = faults_seen;
    clks(40 * TDIV);
    checks++;
    if (faults_seen != f0) begin
      errors++;
      $display("FAIL R10 faults in reset actual=%0d expected=0", faults_seen - f0);
    end
    supply_ok = 1;
    clks((T0 + P0 + 4) * TDIV);
    check("R10", sys_rst, 1'b0, "released again");

    finish_run();
  end
endmodule